// File: doc/BRIEF.md
# Issue-Stage Vector Element Unroller

This block sits at the issue point of a scalar pipeline. It turns one register-register instruction into a run of element operations, as if the instruction had been written out once per element. The operations go downstream in program order and in the same form as ordinary scalar instructions, so later stages need no vector logic. Whether an instruction expands depends on a tag table. It has one tag for each architectural register, and each tag marks that register as scalar or vector and may force 32-bit elements. A vector-length register sets how many elements are produced. A set-length command writes that register.

Each emitted operation carries three things for each of its three operands: the physical register index, a half-register lane select and the element width. Physical registers are 64 bits wide. An operand forced to 32-bit elements therefore packs two elements into each register, low half first. Source and destination ranges may overlap. Placing the destination one register above a source gives a serial reduction chain without any extra logic.

Both data streams use valid/ready. An instruction is accepted only when `in_valid` and `in_ready` are high on the same edge. `in_ready` stays low from the cycle after acceptance until the downstream side has taken the last element. An output operation moves only when `out_valid` and `out_ready` are high together. While `out_valid` is high and `out_ready` is low, every output field holds its value.

Top module: `vec_unroller`

## Requirements
- R1: Each register has its own tag, and the tags named by rd, rs1 and rs2 apply independently of one another. Tags are read when the instruction is accepted.
- R2: A set-length command (`in_setvl`=1) sets the vector length to min(`in_req`, 8). It then emits one operation with `out_setvl`=1, `out_vl` equal to the new length, `out_rd` equal to `in_rd`, `out_elem`=0 and `out_last`=1.
- R3: An instruction with at least one vector-tagged operand emits exactly as many operations as the current vector length. `out_elem` runs 0, 1, 2 and so on, and `out_last` is high only on the final operation.
- R4: For a vector operand tagged with 32-bit width, element e uses register base+e/2 with `_hi`=e bit 0 (0 is the low half, 1 the high half), and its `_w32` is 1.
- R5: For a vector operand at default width, element e uses register base+e with `_hi`=0 and `_w32`=0.
- R6: A scalar operand gives the same register and `_hi`=0 in every element. Its `_w32` follows its tag.
- R7: Overlapping operand ranges get no special handling. Each operand's index is computed on its own.
- R8: A vector instruction accepted while the vector length is 0 emits no operations, and `in_ready` is high again on the next cycle.
- R9: After reset, `in_ready`=1, `out_valid`=0, `vl`=0 and `err_illegal`=0. `in_ready` is low while `out_valid` is high. The output fields are held while the output is stalled.
- R10: If any vector operand's last element would use a register above 31, `err_illegal` pulses for one cycle, starting with the cycle after acceptance, and no operations are emitted. A last element that lands exactly on register 31 is legal.
- R11: An instruction whose three operands are all scalar emits exactly one operation with `out_elem`=0 and `out_last`=1, whatever the vector length, including 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_we | input | 1 | Tag table write enable |
| tag_idx | input | 5 | Register whose tag is written |
| tag_vec | input | 1 | Tag value: 1 = vector |
| tag_w32 | input | 1 | Tag value: 1 = 32-bit element override |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_setvl | input | 1 | Instruction is a set-length command |
| in_req | input | 8 | Requested length for a set-length command |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| out_valid | output | 1 | Element operation valid |
| out_ready | input | 1 | Downstream accepts the operation |
| out_setvl | output | 1 | Operation is a set-length write-back |
| out_vl | output | 4 | Length value written back by a set-length operation |
| out_elem | output | 3 | Element number |
| out_last | output | 1 | Final operation of the instruction |
| out_rd | output | 5 | Physical destination register |
| out_rd_hi | output | 1 | Destination lane: 1 = high 32 bits |
| out_rd_w32 | output | 1 | Destination element is 32-bit |
| out_rs1 | output | 5 | Physical first source register |
| out_rs1_hi | output | 1 | First source lane |
| out_rs1_w32 | output | 1 | First source element is 32-bit |
| out_rs2 | output | 5 | Physical second source register |
| out_rs2_hi | output | 1 | Second source lane |
| out_rs2_w32 | output | 1 | Second source element is 32-bit |
| err_illegal | output | 1 | One-cycle pulse: register range exceeded |
| vl | output | 4 | Current vector length |

## Verification
Two functions can meet on the same edge: the last element of one instruction leaving the block, and the downstream side stalling or the next instruction waiting to enter. The bench pulls `out_ready` low in a repeating pattern throughout the table walk, so the final element is often accepted only after a stall. Just after the final element is accepted, the bench checks that `out_valid` has dropped and `in_ready` has returned. A directed test holds the first element stalled for two cycles and checks that it does not change and that the input stays closed. Overlapping ranges and the legal and illegal edges of the register file are judged against operand indices computed in the bench from the tags.

// File: rtl/vunroll_pkg.sv
package vunroll_pkg;

  // Per-register tag: vector flag and 32-bit element override.
  typedef struct packed {
    logic vec;
    logic w32;
  } reg_tag_t;

  // Register offset from the base for element e of one operand.
  function automatic logic [7:0] elem_step(input logic [7:0] e,
                                           input logic vec,
                                           input logic w32);
    if (!vec)      return 8'd0;
    else if (w32)  return e >> 1;
    else           return e;
  endfunction

endpackage

// File: rtl/vunroll_tags.sv
module vunroll_tags
  import vunroll_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NRD   = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  reg_tag_t         wtag,
  input  logic [IDX_W-1:0] ridx [NRD],
  output reg_tag_t         rtag [NRD]
);

  reg_tag_t table_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) table_q[i] <= '0;
    end else if (we) begin
      table_q[widx] <= wtag;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rtag[p] = table_q[ridx[p]];
  end

endmodule

// File: rtl/vunroll_lane.sv
module vunroll_lane
  import vunroll_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int EIDX_W = 3
) (
  input  logic [IDX_W-1:0]  base,
  input  reg_tag_t          tag,
  input  logic [EIDX_W-1:0] elem,
  output logic [IDX_W-1:0]  phys,
  output logic              hi,
  output logic              w32
);

  always_comb begin
    phys = base + IDX_W'(elem_step(8'(elem), tag.vec, tag.w32));
    hi   = tag.vec & tag.w32 & elem[0];
    w32  = tag.w32;
  end

endmodule

// File: rtl/vunroll_seq.sv
module vunroll_seq #(
  parameter int CNT_W  = 4,
  parameter int EIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              take,
  output logic              busy,
  output logic [EIDX_W-1:0] elem,
  output logic              last
);

  logic [CNT_W-1:0] total_q;

  assign last = (CNT_W'(elem) + 1'b1) == total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      elem    <= '0;
      total_q <= '0;
    end else if (start) begin
      busy    <= (count != '0);
      elem    <= '0;
      total_q <= count;
    end else if (busy && take) begin
      if (last) busy <= 1'b0;
      else      elem <= elem + 1'b1;
    end
  end

endmodule

// File: rtl/vec_unroller.sv
module vec_unroller
  import vunroll_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int MAXVL = 8,
  parameter int REQ_W = 8,
  localparam int IDX_W  = $clog2(NREG),
  localparam int CNT_W  = $clog2(MAXVL + 1),
  localparam int EIDX_W = $clog2(MAXVL),
  localparam int SUM_W  = IDX_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_we,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic              tag_vec,
  input  logic              tag_w32,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_setvl,
  input  logic [REQ_W-1:0]  in_req,
  input  logic [IDX_W-1:0]  in_rd,
  input  logic [IDX_W-1:0]  in_rs1,
  input  logic [IDX_W-1:0]  in_rs2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_setvl,
  output logic [CNT_W-1:0]  out_vl,
  output logic [EIDX_W-1:0] out_elem,
  output logic              out_last,
  output logic [IDX_W-1:0]  out_rd,
  output logic              out_rd_hi,
  output logic              out_rd_w32,
  output logic [IDX_W-1:0]  out_rs1,
  output logic              out_rs1_hi,
  output logic              out_rs1_w32,
  output logic [IDX_W-1:0]  out_rs2,
  output logic              out_rs2_hi,
  output logic              out_rs2_w32,
  output logic              err_illegal,
  output logic [CNT_W-1:0]  vl
);

  localparam int NOP = 3;  // operand slots: 0 = rd, 1 = rs1, 2 = rs2

  logic [IDX_W-1:0] base_in [NOP];
  reg_tag_t         tag_in  [NOP];
  logic [IDX_W-1:0] base_q  [NOP];
  reg_tag_t         tag_q   [NOP];
  logic [IDX_W-1:0] phys    [NOP];
  logic             hi      [NOP];
  logic             w32     [NOP];
  logic [NOP-1:0]   ovf;

  logic             busy, fire_in, any_vec, illegal, setvl_q, err_q;
  logic [CNT_W-1:0] vl_q, new_vl, count;

  always_comb begin
    base_in[0] = in_rd;
    base_in[1] = in_rs1;
    base_in[2] = in_rs2;
  end

  vunroll_tags #(.NREG(NREG), .NRD(NOP)) u_tags (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (tag_we),
    .widx (tag_idx),
    .wtag ({tag_vec, tag_w32}),
    .ridx (base_in),
    .rtag (tag_in)
  );

  // Range check on the last element of each vector operand.
  for (genvar p = 0; p < NOP; p++) begin : g_chk
    logic [SUM_W-1:0] last_idx;
    assign last_idx = SUM_W'(base_in[p])
                    + SUM_W'(elem_step(8'(vl_q - 1'b1), tag_in[p].vec, tag_in[p].w32));
    assign ovf[p] = tag_in[p].vec && (last_idx > SUM_W'(NREG - 1));
  end

  assign in_ready = !busy;
  assign fire_in  = in_valid && in_ready;
  assign any_vec  = tag_in[0].vec | tag_in[1].vec | tag_in[2].vec;
  assign illegal  = any_vec && (vl_q != '0) && (|ovf);
  assign new_vl   = (in_req > REQ_W'(MAXVL)) ? CNT_W'(MAXVL) : CNT_W'(in_req);

  always_comb begin
    if (in_setvl)     count = CNT_W'(1);
    else if (illegal) count = '0;
    else if (any_vec) count = vl_q;
    else              count = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q    <= '0;
      setvl_q <= 1'b0;
      err_q   <= 1'b0;
      for (int p = 0; p < NOP; p++) begin
        base_q[p] <= '0;
        tag_q[p]  <= '0;
      end
    end else begin
      err_q <= fire_in && !in_setvl && illegal;
      if (fire_in) begin
        setvl_q <= in_setvl;
        if (in_setvl) vl_q <= new_vl;
        for (int p = 0; p < NOP; p++) begin
          base_q[p] <= base_in[p];
          tag_q[p]  <= in_setvl ? reg_tag_t'('0) : tag_in[p];
        end
      end
    end
  end

  vunroll_seq #(.CNT_W(CNT_W), .EIDX_W(EIDX_W)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(fire_in),
    .count(count),
    .take (out_ready),
    .busy (busy),
    .elem (out_elem),
    .last (out_last)
  );

  for (genvar p = 0; p < NOP; p++) begin : g_lane
    vunroll_lane #(.IDX_W(IDX_W), .EIDX_W(EIDX_W)) u_lane (
      .base(base_q[p]),
      .tag (tag_q[p]),
      .elem(out_elem),
      .phys(phys[p]),
      .hi  (hi[p]),
      .w32 (w32[p])
    );
  end

  assign out_valid   = busy;
  assign out_setvl   = setvl_q;
  assign out_vl      = vl_q;
  assign out_rd      = phys[0];
  assign out_rd_hi   = hi[0];
  assign out_rd_w32  = w32[0];
  assign out_rs1     = phys[1];
  assign out_rs1_hi  = hi[1];
  assign out_rs1_w32 = w32[1];
  assign out_rs2     = phys[2];
  assign out_rs2_hi  = hi[2];
  assign out_rs2_w32 = w32[2];
  assign err_illegal = err_q;
  assign vl          = vl_q;

endmodule

// File: rtl/vec_unroller_chk.sv
module vec_unroller_chk #(
  parameter int MAXVL  = 8,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 4,
  parameter int EIDX_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_setvl,
  input logic [EIDX_W-1:0] out_elem,
  input logic              out_last,
  input logic [IDX_W-1:0]  out_rd,
  input logic              out_rd_hi,
  input logic              out_rd_w32,
  input logic              out_rs1_hi,
  input logic              out_rs1_w32,
  input logic              err_illegal,
  input logic [CNT_W-1:0]  vl
);

  p_closed_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_elem) && $stable(out_rd)
                                && $stable(out_last) && $stable(out_rd_hi));

  p_elem_ascends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && (out_elem == $past(out_elem) + 1'b1));

  p_vl_capped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vl <= CNT_W'(MAXVL));

  p_setvl_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_setvl |-> out_last && (out_elem == '0));

  p_err_no_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> !out_valid);

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> !err_illegal);

  p_hi_needs_w32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_rd_hi || out_rs1_hi) |-> (out_rd_hi -> out_rd_w32) && (out_rs1_hi -> out_rs1_w32));

endmodule

bind vec_unroller vec_unroller_chk #(
  .MAXVL(MAXVL), .IDX_W(IDX_W), .CNT_W(CNT_W), .EIDX_W(EIDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_setvl  (out_setvl),
  .out_elem   (out_elem),
  .out_last   (out_last),
  .out_rd     (out_rd),
  .out_rd_hi  (out_rd_hi),
  .out_rd_w32 (out_rd_w32),
  .out_rs1_hi (out_rs1_hi),
  .out_rs1_w32(out_rs1_w32),
  .err_illegal(err_illegal),
  .vl         (vl)
);

// File: tb/test_vec_unroller.sv
module test_vec_unroller;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] req;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [2:0] vec;  // {rd, rs1, rs2}
    logic [2:0] w32;  // {rd, rs1, rs2}
  } case_t;

  localparam int NCASE = 9;
  localparam case_t TBL [NCASE] = '{
    '{8'd8,  5'd4,  5'd20, 5'd20, 3'b100, 3'b100}, // R4 packed dest, R6 scalar sources
    '{8'd8,  5'd8,  5'd21, 5'd20, 3'b100, 3'b000}, // R5 one element per register
    '{8'd3,  5'd5,  5'd5,  5'd4,  3'b111, 3'b000}, // R7 overlap, reduction chain
    '{8'd12, 5'd10, 5'd2,  5'd3,  3'b010, 3'b011}, // R2 cap, R1 independent tags
    '{8'd5,  5'd1,  5'd2,  5'd3,  3'b000, 3'b000}, // R11 all scalar
    '{8'd8,  5'd28, 5'd0,  5'd0,  3'b100, 3'b000}, // R10 past register 31
    '{8'd8,  5'd28, 5'd0,  5'd0,  3'b100, 3'b100}, // R10 ends exactly at 31
    '{8'd0,  5'd3,  5'd0,  5'd0,  3'b100, 3'b000}, // R8 zero length
    '{8'd0,  5'd3,  5'd6,  5'd7,  3'b000, 3'b000}  // R11 scalar with zero length
  };

  logic clk = 0, rst_n = 0;
  logic tag_we = 0, tag_vec = 0, tag_w32 = 0;
  logic [4:0] tag_idx = 0;
  logic in_valid = 0, in_setvl = 0;
  logic [7:0] in_req = 0;
  logic [4:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0;
  logic out_ready = 0;
  logic in_ready, out_valid, out_setvl, out_last, err_illegal;
  logic [3:0] out_vl, vl;
  logic [2:0] out_elem;
  logic [4:0] out_rd, out_rs1, out_rs2;
  logic out_rd_hi, out_rd_w32, out_rs1_hi, out_rs1_w32, out_rs2_hi, out_rs2_w32;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_unroller i_vec_unroller (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int estep(int e, bit v, bit w);
    return v ? (w ? e / 2 : e) : 0;
  endfunction

  task automatic put_tag(input logic [4:0] idx, input bit v, input bit w);
    @(negedge clk);
    tag_we = 1; tag_idx = idx; tag_vec = v; tag_w32 = w;
    @(negedge clk);
    tag_we = 0;
  endtask

  // Presents one instruction; returns at the negedge after acceptance.
  task automatic issue(input bit sv, input logic [7:0] req, input logic [4:0] rd,
                       input logic [4:0] r1, input logic [4:0] r2);
    @(negedge clk);
    chk(in_ready === 1'b1, "R9", "in_ready before issue", in_ready, 1);
    in_valid = 1; in_setvl = sv; in_req = req; in_rd = rd; in_rs1 = r1; in_rs2 = r2;
    @(negedge clk);
    in_valid = 0; in_setvl = 0;
  endtask

  task automatic do_setvl(input logic [7:0] req, input logic [4:0] rd);
    int exp = (req > 8) ? 8 : int'(req);
    issue(1, req, rd, 0, 0);
    chk(out_valid && out_setvl && out_last && out_vl == exp && out_rd == rd
        && out_elem == 0, "R2", "set-length op vl", out_vl, exp);
    chk(vl == exp, "R2", "vl port", vl, exp);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid && in_ready, "R2", "set-length single op", out_valid, 0);
  endtask

  // Drains and checks the element stream of the instruction just accepted.
  task automatic drain(input case_t c, input int vlc);
    bit any_v = |c.vec;
    bit bad = 0;
    int n, e, guard;
    logic [4:0] base [3];
    base[0] = c.rd; base[1] = c.rs1; base[2] = c.rs2;
    if (any_v && vlc != 0)
      for (int p = 0; p < 3; p++)
        if (c.vec[2-p] && (int'(base[p]) + estep(vlc - 1, c.vec[2-p], c.w32[2-p]) > 31)) bad = 1;
    n = bad ? 0 : (any_v ? vlc : 1);
    chk(err_illegal == bad, "R10", "err_illegal after accept", err_illegal, bad);
    chk(out_valid == (n > 0), "R8", "out_valid after accept", out_valid, n > 0);
    e = 0; guard = 0;
    while (e < n && guard < 60) begin
      out_ready = (cyc % 3) != 2;
      if (out_valid && out_ready) begin
        int er  = int'(c.rd)  + estep(e, c.vec[2], c.w32[2]);
        int e1  = int'(c.rs1) + estep(e, c.vec[1], c.w32[1]);
        int e2  = int'(c.rs2) + estep(e, c.vec[0], c.w32[0]);
        bit hr  = c.vec[2] & c.w32[2] & e[0];
        bit h1  = c.vec[1] & c.w32[1] & e[0];
        bit h2  = c.vec[0] & c.w32[0] & e[0];
        chk(out_elem == e && out_last == (e == n - 1) && !out_setvl,
            "R3", "element order", out_elem, e);
        chk(out_rd == er && out_rd_hi == hr && out_rd_w32 == c.w32[2],
            "R4 R5 R7", "dest reg", out_rd, er);
        chk(out_rs1 == e1 && out_rs1_hi == h1 && out_rs1_w32 == c.w32[1]
            && out_rs2 == e2 && out_rs2_hi == h2 && out_rs2_w32 == c.w32[0],
            "R1 R6 R7", "source regs", {out_rs1, out_rs2}, {e1[4:0], e2[4:0]});
        e++;
      end
      guard++;
      @(negedge clk);
    end
    out_ready = 0;
    chk(e == n, "R3", "element count", e, n);
    chk(!out_valid && in_ready, "R9", "idle after last element", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1 && out_valid === 0 && vl === 0 && err_illegal === 0,
        "R9", "reset state", {in_ready, out_valid, err_illegal}, 3'b100);
    rst_n = 1;

    for (int k = 0; k < NCASE; k++) begin
      case_t c = TBL[k];
      int vlc = (c.req > 8) ? 8 : int'(c.req);
      do_setvl(c.req, 5'd31);
      put_tag(c.rd,  c.vec[2], c.w32[2]);
      put_tag(c.rs1, c.vec[1], c.w32[1]);
      put_tag(c.rs2, c.vec[0], c.w32[0]);
      issue(0, 0, c.rd, c.rs1, c.rs2);
      drain(c, vlc);
    end

    // R9 directed: stalled output holds its fields and keeps the input closed.
    do_setvl(8'd4, 5'd0);
    put_tag(5'd4, 1, 0);
    put_tag(5'd9, 0, 0);
    issue(0, 0, 5'd4, 5'd9, 5'd9);
    chk(out_valid && out_elem == 0 && !in_ready, "R9", "stall first", out_elem, 0);
    @(negedge clk);
    chk(out_valid && out_elem == 0 && out_rd == 4 && !in_ready, "R9", "stall hold", out_rd, 4);
    drain('{8'd4, 5'd4, 5'd9, 5'd9, 3'b100, 3'b000}, 4);

    // R1 directed: tag change after acceptance leaves the running op alone.
    issue(0, 0, 5'd4, 5'd9, 5'd9);
    put_tag(5'd4, 0, 0);
    drain('{8'd4, 5'd4, 5'd9, 5'd9, 3'b100, 3'b000}, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule